// File: doc/BRIEF.md
# Flash Write-Protect Range Checker

This block sits in front of a serial flash controller's cycle engine. It decides whether a pending flash cycle may proceed. Each request carries a byte address, a flag that marks a program or erase cycle, and a start strobe. One clock later the block returns a verdict, either allow or block. Only an allowed cycle may go on to the serial pins.

The check uses two kinds of stored setting. The first is a set of protection windows, each with its own enable and a 4 KiB page granularity. Writes and erases that land in an enabled window are refused. Reads are never refused by a window. The second is a fence address. Any access, read or write, below the fence is refused. Every refusal raises a sticky access-blocked flag in the status word. Software clears that flag by writing a one to it.

A lock bit freezes the windows and the fence until reset. It also withholds the write grant for the command tables, which live outside this block. The lock can only be set. The frozen registers still read back normally while the lock is set.

Top module: `fwp_guard`

## Requirements
- R1: After reset the following all read zero: every window register, the fence, the lock bit (status bit 15) and the blocked flag (status bit 3). No verdict is presented.
- R2: A strobe on `req_valid` in one cycle produces `res_valid` in exactly the next cycle, and in no other cycle. While `res_valid` is high, exactly one of `res_allow` and `res_block` is high. While it is low, both are low.
- R3: A window register holds three fields: bit 31 is the enable, bits 23:12 are the limit page and bits 11:0 are the base page. A write whose address bits 23:12 lie between the base page and the limit page, both inclusive, is blocked if the enable is set. A limit page L therefore covers every byte up to {L,12'hFFF}.
- R4: A window whose enable bit is clear has no effect on any request.
- R5: A read (`req_wr`=0) is never blocked by a window. A read at or above the fence is allowed.
- R6: Any request whose address is strictly below the fence is blocked. A request at exactly the fence address passes the fence.
- R7: A blocked verdict sets status bit 3 in the same clock edge that presents the verdict. The bit stays set until status is written with bit 3 = 1. If a set and a clear happen together, the set wins.
- R8: Writing status with bit 15 = 1 sets the lock. Writing status with bit 15 = 0 does not clear it. Only reset clears it.
- R9: While the lock is set, writes to the window registers and the fence are ignored, and their read back is unchanged. `tbl_wr_grant` is 0 whatever the value of `tbl_wr_req`. With the lock clear, `tbl_wr_grant` follows `tbl_wr_req`.
- R10: The register selector works as follows. Values 0 to 2 pick the windows, 3 picks the fence (address in bits 23:0) and 4 picks status. `rd_data` shows the selected register combinationally, with unused bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector for writes |
| cfg_wdata | input | 32 | Register write data |
| rd_sel | input | 3 | Register selector for read back |
| rd_data | output | 32 | Read-back data |
| req_valid | input | 1 | Cycle start strobe |
| req_addr | input | 24 | Cycle byte address |
| req_wr | input | 1 | 1 for program or erase, 0 for read |
| res_valid | output | 1 | Verdict valid, one clock after the strobe |
| res_allow | output | 1 | Cycle may be issued |
| res_block | output | 1 | Cycle refused |
| tbl_wr_req | input | 1 | Request to write the command tables |
| tbl_wr_grant | output | 1 | Command-table write permitted |

## Verification
The assertions check the following on every cycle: the one-cycle verdict timing, the exclusive allow/block outputs, the fence refusal, the pass for reads at or above the fence, the blocked flag following each refusal, the stickiness of the lock, and that locked registers do not move. Only the bench scenarios can show the window geometry. That covers the inclusive base and limit pages, the full last page of a limit, disabled windows, and the blocked flag clearing on a one-write. These depend on the programmed register contents and on specific addresses.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int REG_W    = 32;
  localparam int EN_BIT   = 31;
  localparam int LOCK_BIT = 15;
  localparam int BLK_BIT  = 3;

  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'b00,
    VERDICT_ALLOW = 2'b01,
    VERDICT_BLOCK = 2'b10
  } verdict_e;
endpackage

// File: rtl/fwp_cfg_regs.sv
module fwp_cfg_regs
  import fwp_pkg::*;
#(
  parameter int AW = 24,
  parameter int GB = 12,
  parameter int NR = 3,
  localparam int PW = AW - GB,
  localparam int SW = $clog2(NR + 2)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SW-1:0]              cfg_sel,
  input  logic [REG_W-1:0]           cfg_wdata,
  input  logic                       blk_set,
  output logic [NR-1:0][REG_W-1:0]   rng_q,
  output logic [AW-1:0]              fence_q,
  output logic                       lock_q,
  output logic                       blk_q
);
  localparam logic [SW-1:0] SEL_FENCE = SW'(NR);
  localparam logic [SW-1:0] SEL_STS   = SW'(NR + 1);
  localparam logic [REG_W-1:0] ONE    = REG_W'(1);
  localparam logic [REG_W-1:0] RNG_MASK =
      (ONE << EN_BIT)
    | (((ONE << AW) - ONE) & ~((ONE << GB) - ONE))
    | ((ONE << PW) - ONE);

  logic [NR-1:0][REG_W-1:0] rng_d;
  logic [AW-1:0]            fence_d;
  logic                     lock_d;
  logic                     blk_d;
  logic                     cfg_en;
  logic                     sts_en;

  // register-write enables; lock gates the protected set
  assign cfg_en = cfg_we && !lock_q;
  assign sts_en = cfg_we && (cfg_sel == SEL_STS);

  always_comb begin
    rng_d   = rng_q;
    fence_d = fence_q;
    for (int i = 0; i < NR; i++) begin
      if (cfg_sel == SW'(i)) rng_d[i] = cfg_wdata & RNG_MASK;
    end
    if (cfg_sel == SEL_FENCE) fence_d = cfg_wdata[AW-1:0];
  end

  always_comb begin
    lock_d = lock_q;
    blk_d  = blk_q;
    if (sts_en && cfg_wdata[LOCK_BIT]) lock_d = 1'b1;
    if (sts_en && cfg_wdata[BLK_BIT])  blk_d  = 1'b0;
    if (blk_set)                       blk_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_q   <= '0;
      fence_q <= '0;
    end else if (cfg_en) begin
      rng_q   <= rng_d;
      fence_q <= fence_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      blk_q  <= blk_d;
    end
  end
endmodule

// File: rtl/fwp_win_cmp.sv
module fwp_win_cmp
  import fwp_pkg::*;
#(
  parameter int AW = 24,
  parameter int GB = 12,
  localparam int PW = AW - GB
) (
  input  logic [REG_W-1:0] win,
  input  logic [AW-1:0]    addr,
  output logic             hit
);
  logic [PW-1:0] page;
  logic [PW-1:0] lim_pg;
  logic [PW-1:0] base_pg;

  // limit's low page-offset bits are implicitly all ones, so page compare suffices
  assign page    = addr[AW-1:GB];
  assign lim_pg  = win[AW-1:GB];
  assign base_pg = win[PW-1:0];
  assign hit     = win[EN_BIT] && (page >= base_pg) && (page <= lim_pg);
endmodule

// File: rtl/fwp_decide.sv
module fwp_decide
  import fwp_pkg::*;
#(
  parameter int AW = 24,
  parameter int NR = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [NR-1:0] win_hit,
  input  logic [AW-1:0] fence,
  output logic          blk_set,
  output logic          res_valid,
  output logic          res_allow,
  output logic          res_block
);
  verdict_e verdict_d;
  verdict_e verdict_q;
  logic     below_fence;
  logic     wp_hit;
  logic     refuse;

  assign below_fence = req_addr < fence;
  assign wp_hit      = req_wr && (|win_hit);
  assign refuse      = below_fence || wp_hit;
  assign blk_set     = req_valid && refuse;

  always_comb begin
    verdict_d = VERDICT_NONE;
    if (req_valid) verdict_d = refuse ? VERDICT_BLOCK : VERDICT_ALLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_q <= VERDICT_NONE;
    else        verdict_q <= verdict_d;
  end

  assign res_valid = verdict_q != VERDICT_NONE;
  assign res_allow = verdict_q == VERDICT_ALLOW;
  assign res_block = verdict_q == VERDICT_BLOCK;
endmodule

// File: rtl/fwp_guard.sv
module fwp_guard
  import fwp_pkg::*;
#(
  parameter int AW = 24,
  parameter int GB = 12,
  parameter int NR = 3,
  localparam int SW = $clog2(NR + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [SW-1:0]    rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_wr,
  output logic             res_valid,
  output logic             res_allow,
  output logic             res_block,
  input  logic             tbl_wr_req,
  output logic             tbl_wr_grant
);
  localparam logic [SW-1:0] SEL_FENCE = SW'(NR);
  localparam logic [SW-1:0] SEL_STS   = SW'(NR + 1);

  logic [NR-1:0][REG_W-1:0] rng_q;
  logic [AW-1:0]            fence_q;
  logic                     lock_q;
  logic                     blk_q;
  logic                     blk_set;
  logic [NR-1:0]            win_hit;

  fwp_cfg_regs #(.AW(AW), .GB(GB), .NR(NR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .blk_set   (blk_set),
    .rng_q     (rng_q),
    .fence_q   (fence_q),
    .lock_q    (lock_q),
    .blk_q     (blk_q)
  );

  for (genvar g = 0; g < NR; g++) begin : g_win
    fwp_win_cmp #(.AW(AW), .GB(GB)) u_cmp (
      .win  (rng_q[g]),
      .addr (req_addr),
      .hit  (win_hit[g])
    );
  end

  fwp_decide #(.AW(AW), .NR(NR)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_wr    (req_wr),
    .win_hit   (win_hit),
    .fence     (fence_q),
    .blk_set   (blk_set),
    .res_valid (res_valid),
    .res_allow (res_allow),
    .res_block (res_block)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NR; i++) begin
      if (rd_sel == SW'(i)) rd_data = rng_q[i];
    end
    if (rd_sel == SEL_FENCE) rd_data[AW-1:0] = fence_q;
    if (rd_sel == SEL_STS) begin
      rd_data[LOCK_BIT] = lock_q;
      rd_data[BLK_BIT]  = blk_q;
    end
  end

  assign tbl_wr_grant = tbl_wr_req && !lock_q;
endmodule

// File: rtl/fwp_guard_chk.sv
module fwp_guard_chk #(
  parameter int AW = 24,
  parameter int NR = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic                  req_valid,
  input logic [AW-1:0]         req_addr,
  input logic                  req_wr,
  input logic                  res_valid,
  input logic                  res_allow,
  input logic                  res_block,
  input logic                  tbl_wr_grant,
  input logic [NR-1:0][31:0]   rng_q,
  input logic [AW-1:0]         fence_q,
  input logic                  lock_q,
  input logic                  blk_q
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  assert_one_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_allow != res_block));
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_allow && !res_block));
  assert_read_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wr && req_addr >= fence_q) |=> res_allow);
  assert_fence_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < fence_q) |=> res_block);
  assert_block_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_block |-> blk_q);
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_frozen_fence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && cfg_we) |=> $stable(fence_q));
  assert_frozen_win_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && cfg_we) |=> $stable(rng_q));
  assert_tbl_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_grant |-> !lock_q);
endmodule

bind fwp_guard fwp_guard_chk #(.AW(AW), .NR(NR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .req_wr       (req_wr),
  .res_valid    (res_valid),
  .res_allow    (res_allow),
  .res_block    (res_block),
  .tbl_wr_grant (tbl_wr_grant),
  .rng_q        (rng_q),
  .fence_q      (fence_q),
  .lock_q       (lock_q),
  .blk_q        (blk_q)
);

// File: tb/tb_fwp_guard.sv
module tb_fwp_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic        res_valid, res_allow, res_block;
  logic        tbl_wr_req = 1'b0;
  logic        tbl_wr_grant;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    bit    blk;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  fwp_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_wr(req_wr),
    .res_valid(res_valid), .res_allow(res_allow), .res_block(res_block),
    .tbl_wr_req(tbl_wr_req), .tbl_wr_grant(tbl_wr_grant)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected verdict per presented verdict
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 verdict without request", 32'(res_valid), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(res_block == e.blk && res_allow == !e.blk, e.tag,
                {30'h0, res_allow, res_block}, {30'h0, !e.blk, e.blk});
        end
      end else begin
        check(!res_allow && !res_block, "R2 outputs idle",
              {30'h0, res_allow, res_block}, 32'h0);
      end
    end
  end

  // driver: called at a negedge, holds the strobe one cycle
  task automatic issue(input logic [23:0] a, input bit wr, input bit blk,
                       input string tag);
    exp_t e;
    req_valid = 1'b1;
    req_addr  = a;
    req_wr    = wr;
    e.blk = blk;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] sel, input logic [31:0] exp,
                        input string tag);
    rd_sel = sel;
    #1;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(3'd0, 32'h0, "R1 window0 reset");
    rd_chk(3'd3, 32'h0, "R1 fence reset");
    rd_chk(3'd4, 32'h0, "R1 status reset");
    check(!res_valid, "R1 no verdict", 32'(res_valid), 32'h0);
    issue(24'h000000, 1'b1, 1'b0, "R6 zero fence passes");

    // configuration (R10 mapping)
    wr_reg(3'd0, 32'h801FF100);
    wr_reg(3'd1, 32'h003FF300);
    wr_reg(3'd2, 32'h80800800);
    wr_reg(3'd3, 32'h00040000);
    rd_chk(3'd0, 32'h801FF100, "R10 window0 readback");
    rd_chk(3'd2, 32'h80800800, "R10 window2 readback");
    rd_chk(3'd3, 32'h00040000, "R10 fence readback");

    // R3 window geometry, back-to-back requests (R2)
    issue(24'h100000, 1'b1, 1'b1, "R3 base page start");
    issue(24'h1FFFFF, 1'b1, 1'b1, "R3 last byte of limit page");
    issue(24'h200000, 1'b1, 1'b0, "R3 just above limit");
    issue(24'h0FFFFF, 1'b1, 1'b0, "R3 just below base");
    issue(24'h800FFF, 1'b1, 1'b1, "R3 single page window");
    issue(24'h801000, 1'b1, 1'b0, "R3 past single page");
    issue(24'h350000, 1'b1, 1'b0, "R4 disabled window");
    issue(24'h150000, 1'b0, 1'b0, "R5 read inside window");
    issue(24'h800000, 1'b0, 1'b0, "R5 read inside window2");
    issue(24'h03FFFF, 1'b0, 1'b1, "R6 read below fence");
    issue(24'h040000, 1'b0, 1'b0, "R6 read at fence");
    issue(24'h000010, 1'b1, 1'b1, "R6 write below fence");
    @(negedge clk);
    check(sb.size() == 0, "R2 every request answered", 32'(sb.size()), 32'h0);

    // R7 blocked flag
    rd_chk(3'd4, 32'h00000008, "R7 flag set after block");
    wr_reg(3'd4, 32'h00000008);
    rd_chk(3'd4, 32'h00000000, "R7 flag cleared by one-write");
    issue(24'h500000, 1'b1, 1'b0, "R7 allowed request");
    @(negedge clk);
    rd_chk(3'd4, 32'h00000000, "R7 flag stays clear on allow");

    // R9 table grant before lock
    tbl_wr_req = 1'b1;
    #1;
    check(tbl_wr_grant, "R9 grant while unlocked", 32'(tbl_wr_grant), 32'h1);

    // R8 lock
    wr_reg(3'd4, 32'h00008000);
    rd_chk(3'd4, 32'h00008000, "R8 lock set");
    #1;
    check(!tbl_wr_grant, "R9 grant withheld when locked", 32'(tbl_wr_grant), 32'h0);
    tbl_wr_req = 1'b0;
    wr_reg(3'd0, 32'h00000000);
    wr_reg(3'd3, 32'h00000000);
    rd_chk(3'd0, 32'h801FF100, "R9 window frozen");
    rd_chk(3'd3, 32'h00040000, "R9 fence frozen");
    issue(24'h100000, 1'b1, 1'b1, "R9 window still enforced");
    issue(24'h000000, 1'b0, 1'b1, "R9 fence still enforced");
    @(negedge clk);
    wr_reg(3'd4, 32'h00000000);
    rd_chk(3'd4, 32'h00008008, "R8 lock survives zero write");

    // R1 reset clears lock
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(3'd4, 32'h00000000, "R1 lock cleared by reset");
    rd_chk(3'd0, 32'h00000000, "R1 window cleared by reset");
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R2 scoreboard drained", 32'(sb.size()), 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule